// File: doc/BRIEF.md
# Receive Character Queue with Programmable Interrupt Threshold

This block sits between a serial deserializer and the host register interface of a UART. Each character the deserializer assembles is pushed in together with three error marks: parity, framing and break. The host pops the oldest character by reading the receive data register. The head entry is always visible on the read port, so the data and its marks arrive together.

A write to the FIFO-control register sets three things: whether the queue runs as a sixteen-deep FIFO or as a single holding register, the DMA mode select, and a two-bit code that picks the fill level at which a data-available interrupt request is raised. The same write may carry one-shot flush commands. The receive flush empties this queue, and the transmit flush is passed on as a pulse to the transmit side.

The block reports data ready, a sticky overrun flag and a summary flag that is set while any stored character carries an error mark. The overrun flag is cleared when the host reads the line status.

Top module: `rx_char_fifo`

## Requirements
- R1: After reset, the queue is empty and `data_ready`, `overrun`, `err_present`, `avail_irq`, `dma_sel` and `txclr_pulse` are all low. FIFO mode is off and the trigger code is 00.
- R2: On a `cfg_wr` cycle, bit 0 of `cfg_data` is stored as the FIFO-mode enable, bit 3 as the DMA select (seen on `dma_sel`), and bits 7:6 as the trigger code. Bits 1 and 2 are not stored.
- R3: In FIFO mode the queue holds up to DEPTH (16) characters in arrival order. The read port shows the oldest character with its break, framing and parity marks, and each `rbr_pop` moves to the next one. `fill_level` never exceeds DEPTH.
- R4: `fill_level` equals the number of stored characters, and `data_ready` is high exactly when that number is at least one.
- R5: A push while the queue holds its capacity, with no pop in the same cycle, sets `overrun` and discards the new character, leaving the stored characters unchanged. A push together with a pop while full is accepted.
- R6: `overrun` stays set until a cycle with `stat_rd` high, which clears it. When an overrun and `stat_rd` happen in the same cycle, the flag is set.
- R7: `avail_irq` is high while the fill level is at or above the threshold and low once it drops below. In FIFO mode the threshold is set by the trigger code: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14. With FIFO mode off the threshold is 1.
- R8: A `cfg_wr` with bit 1 set empties the queue on the next edge. A push or pop in that same cycle is dropped without raising `overrun`. The flush is not held: the following cycle accepts pushes normally.
- R9: `txclr_pulse` is high in exactly the cycles where `cfg_wr` is high with bit 2 set, and has no effect on the receive queue.
- R10: With FIFO mode off, the capacity is one character, so a second push without an intervening pop is an overrun.
- R11: A `cfg_wr` that changes the FIFO-mode bit empties the queue.
- R12: `err_present` is high exactly while at least one stored character has any of its three marks set.
- R13: A pop while the queue is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | FIFO-control register write strobe |
| cfg_data | input | 8 | FIFO-control write data |
| rx_push | input | 1 | Deserializer has a character |
| rx_char | input | 8 | Received character |
| rx_perr | input | 1 | Parity error mark of the pushed character |
| rx_ferr | input | 1 | Framing error mark of the pushed character |
| rx_brk | input | 1 | Break mark of the pushed character |
| rbr_pop | input | 1 | Host read of the receive data register |
| stat_rd | input | 1 | Host read of line status, clears overrun |
| rd_char | output | 8 | Oldest stored character (zero when empty) |
| rd_perr | output | 1 | Parity mark of the oldest character |
| rd_ferr | output | 1 | Framing mark of the oldest character |
| rd_brk | output | 1 | Break mark of the oldest character |
| fill_level | output | LVL_W | Number of stored characters |
| data_ready | output | 1 | At least one character held |
| overrun | output | 1 | Sticky overrun flag |
| err_present | output | 1 | Some stored character has an error mark |
| avail_irq | output | 1 | Data-available interrupt request |
| dma_sel | output | 1 | Stored DMA mode select |
| txclr_pulse | output | 1 | Transmit-flush pulse to the transmit queue |

## Verification
On every cycle, the assertions check that the level stays within capacity (one when FIFO mode is off), that data ready tracks the level, and that a full push keeps the level and raises overrun. They also check that overrun is sticky, that a flush empties the queue on the next edge, that an empty pop changes nothing, that the transmit pulse only follows a write, and that the error summary is never set with an empty queue. The bench's scenarios are needed to show arrival order and the marks carried with each character, and which of the four thresholds a given trigger code selects. They also show that a push is accepted when it comes with a pop while full, that a flush drops a push in the same cycle, and that the error summary clears only once the marked character has been read.

// File: rtl/rxf_pkg.sv
// Shared types for the receive character queue.
// Assumes 8-bit characters and the four fixed interrupt thresholds.
package rxf_pkg;
    localparam int CHAR_W = 8;

    typedef struct packed {
        logic              brk;
        logic              ferr;
        logic              perr;
        logic [CHAR_W-1:0] ch;
    } rxf_ent_t;

    // Maps the two-bit trigger code to its fill threshold.
    function automatic logic [4:0] trig_level(input logic [1:0] code);
        case (code)
            2'b00:   return 5'd1;
            2'b01:   return 5'd4;
            2'b10:   return 5'd8;
            default: return 5'd14;
        endcase
    endfunction
endpackage

// File: rtl/rxf_ctrl.sv
// FIFO-control register decode.
// Stores the mode, DMA select and trigger code. Turns the flush bits into
// single-cycle pulses. A change of the mode bit also flushes the receive side.
module rxf_ctrl (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [7:0] wdata,
    output logic       fifo_en,
    output logic       dma_sel,
    output logic [1:0] trig_code,
    output logic       rx_flush,
    output logic       tx_flush
);
    // Holds the stored control fields; the flush bits are never kept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fifo_en   <= 1'b0;
            dma_sel   <= 1'b0;
            trig_code <= 2'b00;
        end else if (wr) begin
            fifo_en   <= wdata[0];
            dma_sel   <= wdata[3];
            trig_code <= wdata[7:6];
        end
    end

    assign rx_flush = wr && (wdata[1] || (wdata[0] != fifo_en));
    assign tx_flush = wr && wdata[2];
endmodule

// File: rtl/rxf_store.sv
// Circular character store with read/write pointers, a fill count and a count
// of stored entries that carry an error mark.
// Assumes flush takes priority over push and pop. A push into a full store is
// accepted only when a pop happens in the same cycle.
module rxf_store
    import rxf_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH),
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          single,
    input  logic          push,
    input  rxf_ent_t      push_ent,
    input  logic          pop,
    output rxf_ent_t      head,
    output logic [CW-1:0] count,
    output logic [CW-1:0] err_cnt,
    output logic          ovr_evt
);
    localparam logic [CW-1:0] FULL_N = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_P = AW'(DEPTH - 1);

    logic [AW-1:0] rptr, wptr;
    logic [CW-1:0] cap;
    logic          full, do_push, do_pop, push_err, head_err;
    rxf_ent_t      slot_q [DEPTH];

    assign cap      = single ? CW'(1) : FULL_N;
    assign full     = count >= cap;
    assign do_pop   = pop && (count != '0) && !flush;
    assign do_push  = push && !flush && (!full || do_pop);
    assign ovr_evt  = push && !flush && full && !do_pop;
    assign head     = slot_q[rptr];
    assign push_err = push_ent.brk || push_ent.ferr || push_ent.perr;
    assign head_err = head.brk || head.ferr || head.perr;

    // One storage slot per entry, written when the write pointer selects it.
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        rxf_ent_t slot;
        always_ff @(posedge clk) begin
            if (do_push && (wptr == AW'(i))) slot <= push_ent;
        end
        assign slot_q[i] = slot;
    end

    // Advances pointers and keeps the fill and error counts.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rptr    <= '0;
            wptr    <= '0;
            count   <= '0;
            err_cnt <= '0;
        end else begin
            if (do_push) wptr <= (wptr == LAST_P) ? '0 : wptr + AW'(1);
            if (do_pop)  rptr <= (rptr == LAST_P) ? '0 : rptr + AW'(1);
            count   <= count + CW'(do_push) - CW'(do_pop);
            err_cnt <= err_cnt + CW'(do_push && push_err) - CW'(do_pop && head_err);
        end
    end
endmodule

// File: rtl/rxf_status.sv
// Status and interrupt request generation from the fill and error counts.
// Assumes the counts are registered, so all outputs are clean after the edge.
module rxf_status
    import rxf_pkg::*;
#(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ovr_evt,
    input  logic          stat_rd,
    input  logic          fifo_en,
    input  logic [1:0]    trig_code,
    input  logic [CW-1:0] count,
    input  logic [CW-1:0] err_cnt,
    output logic          data_ready,
    output logic          overrun,
    output logic          err_present,
    output logic          avail_irq
);
    logic [CW-1:0] thr;

    // Sticky overrun: a new event wins over a clearing status read.
    always_ff @(posedge clk) begin
        if (!rst_n)       overrun <= 1'b0;
        else if (ovr_evt) overrun <= 1'b1;
        else if (stat_rd) overrun <= 1'b0;
    end

    assign thr         = fifo_en ? CW'(trig_level(trig_code)) : CW'(1);
    assign data_ready  = count != '0;
    assign avail_irq   = count >= thr;
    assign err_present = err_cnt != '0;
endmodule

// File: rtl/rx_char_fifo.sv
// Receive character queue with a programmable interrupt threshold.
// Joins the control decode, the store and the status logic. The head entry is
// shown as zero while the queue is empty.
module rx_char_fifo
    import rxf_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [7:0]       cfg_data,
    input  logic             rx_push,
    input  logic [7:0]       rx_char,
    input  logic             rx_perr,
    input  logic             rx_ferr,
    input  logic             rx_brk,
    input  logic             rbr_pop,
    input  logic             stat_rd,
    output logic [7:0]       rd_char,
    output logic             rd_perr,
    output logic             rd_ferr,
    output logic             rd_brk,
    output logic [LVL_W-1:0] fill_level,
    output logic             data_ready,
    output logic             overrun,
    output logic             err_present,
    output logic             avail_irq,
    output logic             dma_sel,
    output logic             txclr_pulse
);
    logic             fifo_en, rx_flush, ovr_evt;
    logic [1:0]       trig_code;
    logic [LVL_W-1:0] err_cnt;
    rxf_ent_t         in_ent, head, shown;

    assign in_ent = '{brk: rx_brk, ferr: rx_ferr, perr: rx_perr, ch: rx_char};

    rxf_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .wdata(cfg_data),
        .fifo_en(fifo_en), .dma_sel(dma_sel), .trig_code(trig_code),
        .rx_flush(rx_flush), .tx_flush(txclr_pulse)
    );

    rxf_store #(.DEPTH(DEPTH), .CW(LVL_W)) u_store (
        .clk(clk), .rst_n(rst_n), .flush(rx_flush), .single(!fifo_en),
        .push(rx_push), .push_ent(in_ent), .pop(rbr_pop),
        .head(head), .count(fill_level), .err_cnt(err_cnt), .ovr_evt(ovr_evt)
    );

    rxf_status #(.CW(LVL_W)) u_stat (
        .clk(clk), .rst_n(rst_n), .ovr_evt(ovr_evt), .stat_rd(stat_rd),
        .fifo_en(fifo_en), .trig_code(trig_code), .count(fill_level),
        .err_cnt(err_cnt), .data_ready(data_ready), .overrun(overrun),
        .err_present(err_present), .avail_irq(avail_irq)
    );

    assign shown   = data_ready ? head : '0;
    assign rd_char = shown.ch;
    assign rd_perr = shown.perr;
    assign rd_ferr = shown.ferr;
    assign rd_brk  = shown.brk;
endmodule

// File: rtl/rxf_checker.sv
// Cycle-level properties of the receive character queue, bound to the top.
// Assumes synchronous active-low reset; every property is disabled in reset.
module rxf_checker #(
    parameter int DEPTH = 16,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_wr,
    input logic [7:0]       cfg_data,
    input logic             rx_push,
    input logic             rbr_pop,
    input logic             stat_rd,
    input logic [LVL_W-1:0] fill_level,
    input logic             data_ready,
    input logic             overrun,
    input logic             err_present,
    input logic             avail_irq,
    input logic             txclr_pulse,
    input logic             fifo_en
);
    logic [LVL_W-1:0] cap_w;
    logic             flushing;

    assign cap_w    = fifo_en ? LVL_W'(DEPTH) : LVL_W'(1);
    assign flushing = cfg_wr && (cfg_data[1] || (cfg_data[0] != fifo_en));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fill_level <= LVL_W'(DEPTH));

    assert_ready_tracks_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
        data_ready == (fill_level != '0));

    assert_full_push_discarded_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && !rbr_pop && !flushing && fill_level == cap_w)
        |=> (overrun && fill_level == $past(fill_level)));

    assert_overrun_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !stat_rd) |=> overrun);

    assert_single_threshold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_en |-> (avail_irq == data_ready));

    assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_data[1]) |=> (fill_level == '0));

    assert_txclr_from_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        txclr_pulse |-> (cfg_wr && cfg_data[2]));

    assert_single_capacity_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_en |-> (fill_level <= LVL_W'(1)));

    assert_err_needs_data_R12: assert property (@(posedge clk) disable iff (!rst_n)
        err_present |-> data_ready);

    assert_empty_pop_ignored_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (rbr_pop && !rx_push && fill_level == '0) |=> (fill_level == '0));
endmodule

bind rx_char_fifo rxf_checker #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
    .rx_push(rx_push), .rbr_pop(rbr_pop), .stat_rd(stat_rd),
    .fill_level(fill_level), .data_ready(data_ready), .overrun(overrun),
    .err_present(err_present), .avail_irq(avail_irq),
    .txclr_pulse(txclr_pulse), .fifo_en(fifo_en)
);

// File: tb/sim_rx_char_fifo.sv
// Self-checking bench: a behavioural queue model is updated at each rising
// edge and compared 3 ns later, before inputs change at the falling edge.
module sim_rx_char_fifo;
    localparam int DEPTH = 16;
    localparam int LW    = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          b_wr = 0, b_push = 0, b_pe = 0, b_fe = 0, b_bk = 0, b_pop = 0, b_srd = 0;
    logic [7:0]    b_d = 0, b_ch = 0;
    logic [7:0]    rd_char;
    logic          rd_perr, rd_ferr, rd_brk, data_ready, overrun, err_present;
    logic          avail_irq, dma_sel, txclr_pulse;
    logic [LW-1:0] fill_level;

    int nchk = 0;
    int nfail = 0;

    // Reference model state
    logic [10:0] q[$];
    logic        m_ovr = 0, m_fen = 0, m_dma = 0;
    logic [1:0]  m_trig = 0;

    always #4 clk = ~clk;

    rx_char_fifo #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(b_wr), .cfg_data(b_d),
        .rx_push(b_push), .rx_char(b_ch), .rx_perr(b_pe), .rx_ferr(b_fe),
        .rx_brk(b_bk), .rbr_pop(b_pop), .stat_rd(b_srd),
        .rd_char(rd_char), .rd_perr(rd_perr), .rd_ferr(rd_ferr), .rd_brk(rd_brk),
        .fill_level(fill_level), .data_ready(data_ready), .overrun(overrun),
        .err_present(err_present), .avail_irq(avail_irq), .dma_sel(dma_sel),
        .txclr_pulse(txclr_pulse)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int thr_of();
        if (!m_fen) return 1;
        case (m_trig)
            2'd0: return 1;
            2'd1: return 4;
            2'd2: return 8;
            default: return 14;
        endcase
    endfunction

    // Model update at each edge, then a full output comparison.
    always begin
        @(posedge clk);
        if (!rst_n) begin
            q.delete(); m_ovr = 0; m_fen = 0; m_dma = 0; m_trig = 0;
        end else begin
            automatic int  cap   = m_fen ? DEPTH : 1;
            automatic bit  flush = b_wr && (b_d[1] || (b_d[0] != m_fen));
            automatic bit  popd  = b_pop && (q.size() > 0);
            automatic bit  full  = q.size() >= cap;
            automatic bit  oset  = 0;
            if (flush) q.delete();
            else begin
                if (popd) void'(q.pop_front());
                if (b_push) begin
                    if (!full || popd) q.push_back({b_bk, b_fe, b_pe, b_ch});
                    else oset = 1;
                end
            end
            if (oset) m_ovr = 1;
            else if (b_srd) m_ovr = 0;
            if (b_wr) begin m_fen = b_d[0]; m_dma = b_d[3]; m_trig = b_d[7:6]; end
        end
        #3;
        begin
            automatic logic [10:0] hd = (q.size() > 0) ? q[0] : 11'h0;
            automatic bit e = 0;
            foreach (q[k]) if (|q[k][10:8]) e = 1;
            chk(32'(fill_level), 32'(q.size()), "R4 fill_level");
            chk(32'(data_ready), 32'(q.size() > 0), "R4 data_ready");
            chk(32'({rd_brk, rd_ferr, rd_perr, rd_char}), 32'(hd), "R3 head entry");
            chk(32'(overrun), 32'(m_ovr), "R5 R6 overrun");
            chk(32'(avail_irq), 32'(q.size() >= thr_of()), "R7 avail_irq");
            chk(32'(err_present), 32'(e), "R12 err_present");
            chk(32'(txclr_pulse), 32'(rst_n && b_wr && b_d[2]), "R9 txclr_pulse");
            chk(32'(dma_sel), 32'(m_dma), "R2 dma_sel");
        end
    end

    task automatic step(input bit wr, input logic [7:0] d, input bit push,
                        input logic [7:0] ch, input logic [2:0] flg,
                        input bit pop, input bit srd);
        @(negedge clk);
        b_wr = wr; b_d = d; b_push = push; b_ch = ch;
        b_bk = flg[2]; b_fe = flg[1]; b_pe = flg[0]; b_pop = pop; b_srd = srd;
        @(posedge clk);
        #3;
    endtask

    task automatic idle();           step(0, 8'h00, 0, 8'h00, 3'b000, 0, 0); endtask
    task automatic cfg(input logic [7:0] d); step(1, d, 0, 8'h00, 3'b000, 0, 0); endtask
    task automatic push(input logic [7:0] c, input logic [2:0] f); step(0, 8'h00, 1, c, f, 0, 0); endtask
    task automatic pop();            step(0, 8'h00, 0, 8'h00, 3'b000, 1, 0); endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired (all requirements) actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        idle();
        chk(32'(fill_level), 0, "R1 level after reset");
        chk(32'({data_ready, overrun, err_present, avail_irq, dma_sel}), 0, "R1 flags after reset");

        // FIFO mode, threshold 1; fill to capacity with one marked entry.
        cfg(8'h01);
        for (int i = 0; i < DEPTH; i++) push(8'(i), (i == 5) ? 3'b001 : 3'b000);
        chk(32'(fill_level), 16, "R3 full level");
        chk(32'(err_present), 1, "R12 marked entry stored");
        push(8'hEE, 3'b000);
        chk(32'(overrun), 1, "R5 overrun on full push");
        chk(32'(fill_level), 16, "R5 level kept");
        chk(32'(rd_char), 0, "R5 head unchanged");
        idle();
        chk(32'(overrun), 1, "R6 overrun sticky");
        step(0, 8'h00, 0, 8'h00, 3'b000, 0, 1);
        chk(32'(overrun), 0, "R6 cleared by status read");
        step(0, 8'h00, 1, 8'hAA, 3'b000, 1, 0);
        chk(32'(fill_level), 16, "R5 push with pop accepted");
        chk(32'(overrun), 0, "R5 no overrun with pop");
        for (int i = 1; i < DEPTH; i++) begin
            chk(32'(rd_char), 32'(i), "R3 arrival order");
            if (i == 5) chk(32'(rd_perr), 1, "R3 parity mark carried");
            pop();
            if (i == 5) chk(32'(err_present), 0, "R12 cleared after marked pop");
        end
        chk(32'(rd_char), 32'hAA, "R3 last entry");
        pop();
        pop();
        chk(32'(fill_level), 0, "R13 empty pop ignored");

        // Thresholds 4, 8, 14.
        cfg(8'h41);
        for (int i = 0; i < 3; i++) push(8'(i), 3'b000);
        chk(32'(avail_irq), 0, "R7 below 4");
        push(8'h03, 3'b000);
        chk(32'(avail_irq), 1, "R7 at 4");
        cfg(8'h81);
        chk(32'(fill_level), 4, "R2 threshold write keeps data");
        chk(32'(avail_irq), 0, "R7 below 8");
        for (int i = 0; i < 4; i++) push(8'(i), 3'b100);
        chk(32'(avail_irq), 1, "R7 at 8");
        cfg(8'hC1);
        for (int i = 0; i < 5; i++) push(8'(i), 3'b010);
        chk(32'(avail_irq), 0, "R7 at 13 of 14");
        push(8'h55, 3'b000);
        chk(32'(avail_irq), 1, "R7 at 14");
        pop();
        chk(32'(avail_irq), 0, "R7 drops below 14");

        // Flush with push in the same cycle.
        step(1, 8'hC3, 1, 8'h77, 3'b000, 0, 0);
        chk(32'(fill_level), 0, "R8 flush empties");
        chk(32'(overrun), 0, "R8 no overrun on flush");
        push(8'h12, 3'b000);
        chk(32'(fill_level), 1, "R8 flush is a pulse");
        cfg(8'hC5);
        chk(32'(txclr_pulse), 1, "R9 tx clear pulse");
        chk(32'(fill_level), 1, "R9 receive side untouched");
        idle();
        chk(32'(txclr_pulse), 0, "R9 pulse ends");

        // Leave FIFO mode: flush, then single holding register.
        cfg(8'h00);
        chk(32'(fill_level), 0, "R11 mode change flushes");
        push(8'h31, 3'b000);
        chk(32'(avail_irq), 1, "R7 single-mode threshold 1");
        push(8'h32, 3'b000);
        chk(32'(overrun), 1, "R10 second push overruns");
        chk(32'(rd_char), 32'h31, "R10 held char kept");
        cfg(8'h08);
        chk(32'(dma_sel), 1, "R2 dma select stored");
        cfg(8'h00);

        // Random traffic compared against the model every cycle.
        for (int n = 0; n < 4000; n++) begin
            automatic logic [7:0] d = 8'($urandom);
            d[0] = (($urandom % 8) != 0);
            step(($urandom % 40) == 0, d, ($urandom % 2) == 0, 8'($urandom),
                 {(($urandom % 8) == 0), (($urandom % 8) == 0), (($urandom % 8) == 0)},
                 ($urandom % 3) == 0, ($urandom % 10) == 0);
        end
        idle();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule